// File: doc/BRIEF.md
# Coprocessor Control Wrapper with Exception Recovery

This block sits between a host bus and an attached coprocessor core. It is an APB slave holding a small register window. Through this window a host sets where the core starts fetching and where it writes results, launches the core and watches its progress. The live DMA state lines of the core are mirrored into a status word. Every hardware exception the core raises is latched in that word until software acknowledges it, so any bus master can find out why the core last stopped.

When the core raises a stack overflow, null reference or index-out-of-bounds exception, the wrapper resets the core by itself. It pulls the core reset low for a fixed number of cycles and then drops the run request, so the core comes back clean and idle without any help from the host. If automatic recovery is switched off, the exception only halts the core and is recorded.

Register layout (32-bit data, byte offsets): 0x0 fetch-start address, 0x4 result address, 0x8 control (bit 0 run, bit 1 auto-recovery enable), 0xC status (bit 0 DMA idle, bit 1 DMA busy, bit 2 DMA error, bit 3 stack overflow, bit 4 null reference, bit 5 index out of bounds). All other bits read as zero.

Top module: `cpw_ctrl_wrap`

## Requirements
- R1: After reset, both address registers read 0, control reads 0x2 (run off, auto-recovery on), no exception bit is set, core_rst_n is high and core_run is low.
- R2: Words written at offset 0x0 and 0x4 read back unchanged and drive core_start_addr and core_out_addr.
- R3: Control bit 0 (run) drives core_run while the core is out of reset; control bit 1 enables auto-recovery; both read back at offset 0x8.
- R4: Status bits 2:0 show the live dma_err, dma_busy, dma_idle inputs (bit 2, 1, 0) and are not changed by writes.
- R5: A rising edge on exc_stack_ovf, exc_null_ref or exc_index_oob sets status bit 3, 4 or 5 respectively; an input held high does not raise a second event.
- R6: Writing 1 to a status exception bit clears it, writing 0 leaves it; a new rising edge in the same cycle as the clearing write keeps the bit set.
- R7: With auto-recovery on, an exception drives core_rst_n low for exactly 16 cycles; on the edge that releases it the run bit is cleared, so core_run stays low.
- R8: Exception bits stay set through and after the automatic core reset.
- R9: With auto-recovery off, an exception clears the run bit on the next edge and core_rst_n stays high.
- R10: Reads at offsets other than 0x0, 0x4, 0x8, 0xC return 0, writes there change nothing, and pready is always 1.
- R11: An exception arriving while a recovery pulse is active is latched but does not lengthen the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the wrapper |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 4 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, constant high |
| exc_stack_ovf | input | 1 | Core stack overflow exception |
| exc_null_ref | input | 1 | Core null reference exception |
| exc_index_oob | input | 1 | Core index out of bounds exception |
| dma_idle | input | 1 | Core DMA idle |
| dma_busy | input | 1 | Core DMA busy |
| dma_err | input | 1 | Core DMA error |
| core_rst_n | output | 1 | Active-low reset to the core |
| core_run | output | 1 | Start request to the core |
| core_start_addr | output | 32 | Fetch start address for the core |
| core_out_addr | output | 32 | Result address for the core |

## Verification
On every cycle the assertions check that pready stays high, that the recovery pulse lasts exactly 16 cycles, that the core never runs in reset or right after release, that a pulse never starts with recovery disabled, that exception bits rise after an input edge and only fall on an acknowledging write, and that the status word mirrors the DMA lines. The bench scenarios show what a property cannot see in one step: register read-back through the bus, the held-level exception that must not retrigger, a second exception arriving during a pulse, the set-against-clear collision, and halting without a reset pulse.

// File: rtl/cpw_pkg.sv
package cpw_pkg;
    // Byte offsets of the register window
    localparam int OFS_START = 'h0;
    localparam int OFS_OUT   = 'h4;
    localparam int OFS_CTRL  = 'h8;
    localparam int OFS_STAT  = 'hC;

    // Control register fields
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_AUTO_BIT = 1;

    // Exception source order inside the sticky vector
    typedef enum logic [1:0] {
        EXC_STACK  = 2'd0,
        EXC_NULL   = 2'd1,
        EXC_BOUNDS = 2'd2
    } exc_src_e;
endpackage

// File: rtl/cpw_exc_capture.sv
module cpw_exc_capture #(
    parameter int NUM_EXC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXC-1:0] exc_i,
    input  logic [NUM_EXC-1:0] clr_i,
    output logic [NUM_EXC-1:0] sticky_o,
    output logic               event_o
);
    typedef struct packed {
        logic [NUM_EXC-1:0] prev;
        logic [NUM_EXC-1:0] sticky;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [NUM_EXC-1:0] rise;

    for (genvar g = 0; g < NUM_EXC; g++) begin : g_edge
        assign rise[g] = exc_i[g] & ~cap_q.prev[g];
    end

    always_comb begin
        cap_d        = cap_q;
        cap_d.prev   = exc_i;
        // a new edge wins over an acknowledge in the same cycle
        cap_d.sticky = (cap_q.sticky & ~clr_i) | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign sticky_o = cap_q.sticky;
    assign event_o  = |rise;
endmodule

// File: rtl/cpw_recovery_timer.sv
module cpw_recovery_timer #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger_i,
    output logic core_rst_n_o,
    output logic release_o
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt != '0)
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        else if (trigger_i)
            tmr_d.cnt = CNT_W'(RST_CYCLES);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign core_rst_n_o = (tmr_q.cnt == '0);
    assign release_o    = (tmr_q.cnt == CNT_W'(1));
endmodule

// File: rtl/cpw_apb_regs.sv
module cpw_apb_regs
    import cpw_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int NUM_DMA = 3,
    parameter int NUM_EXC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [DATA_W-1:0]  pwdata,
    output logic [DATA_W-1:0]  prdata,
    input  logic [NUM_DMA-1:0] dma_i,
    input  logic [NUM_EXC-1:0] sticky_i,
    input  logic               exc_event_i,
    input  logic               release_i,
    output logic [DATA_W-1:0]  start_addr_o,
    output logic [DATA_W-1:0]  out_addr_o,
    output logic               run_o,
    output logic               auto_en_o,
    output logic [NUM_EXC-1:0] clr_o
);
    localparam int EXC_LSB = NUM_DMA;
    localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFS_START);
    localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(OFS_OUT);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);

    typedef struct packed {
        logic [DATA_W-1:0] start_addr;
        logic [DATA_W-1:0] out_addr;
        logic              run;
        logic              auto_en;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wr_en;
    logic [DATA_W-1:0] rd_word;

    assign wr_en = psel & penable & pwrite;

    always_comb begin
        regs_d = regs_q;
        clr_o  = '0;
        if (wr_en) begin
            case (paddr)
                A_START: regs_d.start_addr = pwdata;
                A_OUT:   regs_d.out_addr   = pwdata;
                A_CTRL: begin
                    regs_d.run     = pwdata[CTRL_RUN_BIT];
                    regs_d.auto_en = pwdata[CTRL_AUTO_BIT];
                end
                A_STAT:  clr_o = pwdata[EXC_LSB +: NUM_EXC];
                default: ;
            endcase
        end
        // recovery end and halting take priority over a host write
        if (release_i)
            regs_d.run = 1'b0;
        if (exc_event_i && !regs_q.auto_en)
            regs_d.run = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q            <= '0;
            regs_q.auto_en    <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_word = '0;
        case (paddr)
            A_START: rd_word = regs_q.start_addr;
            A_OUT:   rd_word = regs_q.out_addr;
            A_CTRL: begin
                rd_word[CTRL_RUN_BIT]  = regs_q.run;
                rd_word[CTRL_AUTO_BIT] = regs_q.auto_en;
            end
            A_STAT: begin
                rd_word[NUM_DMA-1:0]         = dma_i;
                rd_word[EXC_LSB +: NUM_EXC]  = sticky_i;
            end
            default: rd_word = '0;
        endcase
    end

    assign prdata       = psel ? rd_word : '0;
    assign start_addr_o = regs_q.start_addr;
    assign out_addr_o   = regs_q.out_addr;
    assign run_o        = regs_q.run;
    assign auto_en_o    = regs_q.auto_en;
endmodule

// File: rtl/cpw_ctrl_wrap.sv
module cpw_ctrl_wrap
    import cpw_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    input  logic              exc_stack_ovf,
    input  logic              exc_null_ref,
    input  logic              exc_index_oob,
    input  logic              dma_idle,
    input  logic              dma_busy,
    input  logic              dma_err,
    output logic              core_rst_n,
    output logic              core_run,
    output logic [DATA_W-1:0] core_start_addr,
    output logic [DATA_W-1:0] core_out_addr
);
    localparam int NUM_EXC = 3;
    localparam int NUM_DMA = 3;
    localparam int EXC_LSB = NUM_DMA;

    logic [NUM_EXC-1:0] exc_vec;
    logic [NUM_EXC-1:0] exc_sticky;
    logic [NUM_EXC-1:0] exc_clr;
    logic [NUM_DMA-1:0] dma_vec;
    logic               exc_event;
    logic               auto_en;
    logic               run_req;
    logic               rel_pulse;
    logic               core_rst_n_int;

    assign exc_vec[EXC_STACK]  = exc_stack_ovf;
    assign exc_vec[EXC_NULL]   = exc_null_ref;
    assign exc_vec[EXC_BOUNDS] = exc_index_oob;
    assign dma_vec             = {dma_err, dma_busy, dma_idle};

    cpw_exc_capture #(.NUM_EXC(NUM_EXC)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .exc_i    (exc_vec),
        .clr_i    (exc_clr),
        .sticky_o (exc_sticky),
        .event_o  (exc_event)
    );

    cpw_recovery_timer #(.RST_CYCLES(RST_CYCLES)) u_tmr (
        .clk          (clk),
        .rst_n        (rst_n),
        .trigger_i    (exc_event & auto_en),
        .core_rst_n_o (core_rst_n_int),
        .release_o    (rel_pulse)
    );

    cpw_apb_regs #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .NUM_DMA (NUM_DMA),
        .NUM_EXC (NUM_EXC)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .psel         (psel),
        .penable      (penable),
        .pwrite       (pwrite),
        .paddr        (paddr),
        .pwdata       (pwdata),
        .prdata       (prdata),
        .dma_i        (dma_vec),
        .sticky_i     (exc_sticky),
        .exc_event_i  (exc_event),
        .release_i    (rel_pulse),
        .start_addr_o (core_start_addr),
        .out_addr_o   (core_out_addr),
        .run_o        (run_req),
        .auto_en_o    (auto_en),
        .clr_o        (exc_clr)
    );

    assign pready     = 1'b1;
    assign core_rst_n = core_rst_n_int;
    assign core_run   = run_req & core_rst_n_int;
endmodule

// File: rtl/cpw_ctrl_wrap_chk.sv
module cpw_ctrl_wrap_chk #(
    parameter int ADDR_W     = 4,
    parameter int RST_CYCLES = 16,
    parameter int NUM_EXC    = 3,
    parameter int NUM_DMA    = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [ADDR_W-1:0]  paddr,
    input logic [NUM_EXC-1:0] ack_bits,
    input logic [NUM_DMA-1:0] rd_dma,
    input logic               pready,
    input logic [NUM_DMA-1:0] dma_vec,
    input logic [NUM_EXC-1:0] exc_vec,
    input logic               core_rst_n,
    input logic               core_run,
    input logic               auto_en,
    input logic [NUM_EXC-1:0] sticky
);
    localparam int LC_W = $clog2(RST_CYCLES + 2);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('hC);

    logic [LC_W-1:0] low_cnt;
    logic            wr_stat;

    assign wr_stat = psel & penable & pwrite & (paddr == A_STAT);

    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (core_rst_n)
            low_cnt <= '0;
        else if (low_cnt != LC_W'(RST_CYCLES + 1))
            low_cnt <= low_cnt + 1'b1;
    end

    AST_PREADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        pready) else $error("pready low"); // R10

    AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> (low_cnt == LC_W'(RST_CYCLES))) else $error("pulse length"); // R7

    AST_IDLE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst_n |-> !core_run) else $error("run in reset"); // R7

    AST_IDLE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> !core_run) else $error("run after release"); // R7

    AST_NO_PULSE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_n) |-> $past(auto_en)) else $error("pulse while disabled"); // R9

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sticky) & ~sticky & ~($past(wr_stat) ? $past(ack_bits) : '0)) == '0)
        else $error("sticky bit lost"); // R8

    AST_DMA_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && paddr == A_STAT) |-> (rd_dma == dma_vec)) else $error("dma mirror"); // R4

    for (genvar g = 0; g < NUM_EXC; g++) begin : g_set
        AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (exc_vec[g] && !$past(exc_vec[g])) |=> sticky[g]) else $error("edge lost"); // R5
    end
endmodule

bind cpw_ctrl_wrap cpw_ctrl_wrap_chk #(
    .ADDR_W     (ADDR_W),
    .RST_CYCLES (RST_CYCLES),
    .NUM_EXC    (NUM_EXC),
    .NUM_DMA    (NUM_DMA)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .ack_bits   (pwdata[EXC_LSB +: NUM_EXC]),
    .rd_dma     (prdata[NUM_DMA-1:0]),
    .pready     (pready),
    .dma_vec    (dma_vec),
    .exc_vec    (exc_vec),
    .core_rst_n (core_rst_n),
    .core_run   (core_run),
    .auto_en    (auto_en),
    .sticky     (exc_sticky)
);

// File: tb/tb_cpw_ctrl_wrap.sv
module tb_cpw_ctrl_wrap;
    localparam int CLK_P = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [3:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        exc_stack_ovf = 1'b0, exc_null_ref = 1'b0, exc_index_oob = 1'b0;
    logic        dma_idle = 1'b1, dma_busy = 1'b0, dma_err = 1'b0;
    logic        core_rst_n, core_run;
    logic [31:0] core_start_addr, core_out_addr;

    always #(CLK_P/2) clk = ~clk;

    cpw_ctrl_wrap dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .exc_stack_ovf(exc_stack_ovf), .exc_null_ref(exc_null_ref),
        .exc_index_oob(exc_index_oob), .dma_idle(dma_idle), .dma_busy(dma_busy),
        .dma_err(dma_err), .core_rst_n(core_rst_n), .core_run(core_run),
        .core_start_addr(core_start_addr), .core_out_addr(core_out_addr)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int       n_chk = 0;
    int       n_fail = 0;
    event     smp_ev;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: compares each sampled read against the queued expectation
    initial begin
        forever begin
            @(smp_ev);
            if (sb_q.size() == 0) begin
                check(prdata, 32'hx, "scoreboard underflow");
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(prdata, it.exp, it.tag);
            end
        end
    end

    task automatic apb_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        sb_item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #2 -> smp_ev;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    // counts negedges with core_rst_n low, starting right after an exception edge
    task automatic count_low(output int cnt, input bit inject_oob);
        cnt = 0;
        while (!core_rst_n && cnt < 100) begin
            cnt++;
            exc_index_oob = inject_oob && (cnt == 5);
            @(negedge clk);
        end
        exc_index_oob = 1'b0;
    endtask

    task automatic count_high(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (core_rst_n) highs++;
        end
    endtask

    task automatic finish_run();
        @(negedge clk);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cnt;
        int highs;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check({31'b0, core_rst_n}, 32'h1, "R1 core_rst_n after reset");
        check({31'b0, core_run},   32'h0, "R1 core_run after reset");
        check({31'b0, pready},     32'h1, "R10 pready");
        apb_rd(4'h0, 32'h0, "R1 start addr reset");
        apb_rd(4'h4, 32'h0, "R1 out addr reset");
        apb_rd(4'h8, 32'h2, "R1 control reset");
        apb_rd(4'hC, 32'h1, "R1 status reset");

        // R2 address registers
        apb_wr(4'h0, 32'h0000_1000);
        apb_wr(4'h4, 32'hA5A5_2000);
        apb_rd(4'h0, 32'h0000_1000, "R2 start addr readback");
        apb_rd(4'h4, 32'hA5A5_2000, "R2 out addr readback");
        check(core_start_addr, 32'h0000_1000, "R2 core_start_addr");
        check(core_out_addr,   32'hA5A5_2000, "R2 core_out_addr");

        // R4 DMA mirror, read-only
        dma_idle = 1'b0; dma_busy = 1'b1;
        apb_rd(4'hC, 32'h2, "R4 dma busy");
        dma_busy = 1'b0; dma_err = 1'b1;
        apb_rd(4'hC, 32'h4, "R4 dma error");
        dma_err = 1'b0; dma_idle = 1'b1;
        apb_wr(4'hC, 32'hFFFF_FFFF);
        apb_rd(4'hC, 32'h1, "R4 status write has no effect");

        // R10 unmapped offsets
        apb_wr(4'h2, 32'hDEAD_BEEF);
        apb_wr(4'h6, 32'hDEAD_BEEF);
        apb_rd(4'h2, 32'h0, "R10 unmapped read 0x2");
        apb_rd(4'hE, 32'h0, "R10 unmapped read 0xE");
        apb_rd(4'h0, 32'h0000_1000, "R10 unmapped write no effect");
        apb_rd(4'h4, 32'hA5A5_2000, "R10 unmapped write no effect out");

        // R3 run
        apb_wr(4'h8, 32'h3);
        apb_rd(4'h8, 32'h3, "R3 control readback");
        check({31'b0, core_run}, 32'h1, "R3 core_run");

        // R7/R5 stack overflow held high, automatic recovery
        @(negedge clk);
        exc_stack_ovf = 1'b1;
        @(negedge clk);
        check({31'b0, core_run}, 32'h0, "R7 core idle during pulse");
        count_low(cnt, 1'b0);
        check(cnt, 16, "R7 pulse length");
        check({31'b0, core_run}, 32'h0, "R7 run cleared at release");
        count_high(20, highs);
        check(highs, 20, "R5 held level no retrigger");
        exc_stack_ovf = 1'b0;
        apb_rd(4'h8, 32'h2, "R7 run bit cleared");
        apb_rd(4'hC, 32'h9, "R8 stack bit survives reset");

        // R11 second exception during pulse
        apb_wr(4'h8, 32'h3);
        @(negedge clk);
        exc_null_ref = 1'b1;
        @(negedge clk);
        exc_null_ref = 1'b0;
        count_low(cnt, 1'b1);
        check(cnt, 16, "R11 pulse not extended");
        apb_rd(4'hC, 32'h39, "R11 all exception bits latched");

        // R6 write-1-to-clear
        apb_wr(4'hC, 32'h10);
        apb_rd(4'hC, 32'h29, "R6 clear null bit only");
        apb_wr(4'hC, 32'h0);
        apb_rd(4'hC, 32'h29, "R6 write zero keeps bits");
        apb_wr(4'hC, 32'h38);
        apb_rd(4'hC, 32'h1, "R6 clear all");

        // R6 set wins over clear; auto-recovery off
        apb_wr(4'h8, 32'h0);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = 4'hC; pwdata = 32'h8; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        exc_stack_ovf = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        exc_stack_ovf = 1'b0;
        apb_rd(4'hC, 32'h9, "R6 set wins over clear");

        // R9 halt without pulse
        apb_wr(4'hC, 32'h38);
        apb_wr(4'h8, 32'h1);
        check({31'b0, core_run}, 32'h1, "R9 core running");
        @(negedge clk);
        exc_index_oob = 1'b1;
        @(negedge clk);
        exc_index_oob = 1'b0;
        check({31'b0, core_run}, 32'h0, "R9 halted");
        check({31'b0, core_rst_n}, 32'h1, "R9 no reset pulse");
        count_high(20, highs);
        check(highs, 20, "R9 reset stays high");
        apb_rd(4'h8, 32'h0, "R9 run bit cleared");
        apb_rd(4'hC, 32'h21, "R9 bounds bit latched");

        finish_run();
    end
endmodule